// File: doc/BRIEF.md
# Fixed-Weight Neural Compression Layer

This block is the hidden (encoding) layer of a small image-compression network with 16 inputs, 4 hidden units and 16 outputs. A tile of 16x16 pixels is presented one column at a time. Each column is 16 unsigned 8-bit intensities and is offered on a valid/ready stream. The block multiplies the column by a constant 4x16 matrix of trained signed fractional weights and returns four signed results for that column. A full tile therefore gives a 4x16 compressed result.

The weights are fixed at build time through a parameter, in Q1.12 fixed point (range -4096..4095, so magnitude up to 1.0). Each product is built from the canonical-signed-digit recoding of its weight. This turns every multiply into a short sum of signed, shifted copies of the pixel, so there is no general multiplier. A mode input chooses between the raw linear result and a clipping nonlinearity. Start-of-tile and end-of-tile markers frame the output stream for the quantizer that follows.

Top module: `fixed_weight_encoder`

## Requirements
- R1: A synchronous active-high reset clears the pipeline and the output column count. While reset is held and right after it, out_valid is 0, in_ready is 1, out_eot is 0, and the linear mode is selected.
- R2: In linear mode, output i (bits [11*i+10 : 11*i] of out_res) equals the low 11 bits of floor(sum over j of W[i][j]*p[j] / 4096). Here p[j] is the pixel in bits [8*j+7 : 8*j] of in_pix and W[i][j] is the Q1.12 weight. Results that do not fit in 11 bits wrap.
- R3: A column accepted on a clock edge (in_valid and in_ready both high) gives out_valid high with its four results after the following edge, as long as the output is not stalled in between.
- R4: While out_valid is high and out_ready is low, in_ready is low, and out_res, out_sot and out_valid hold their values.
- R5: When act_sel is 1 (clipping mode), each output is floor(sum/4096) clamped to the range -512..511.
- R6: act_sel is taken into the block only while the block is idle: no column in flight and the output column count at zero. A change of act_sel in the middle of a tile has no effect on the columns of that tile.
- R7: out_sot is high on an output column if and only if in_sot was high when that column was accepted.
- R8: out_eot is high on every 16th output column counted since reset, and only together with out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input column offered |
| in_ready | output | 1 | Block can take a column |
| in_pix | input | 128 | 16 pixels, pixel j in bits [8j+7:8j] |
| in_sot | input | 1 | Column is the first of a tile |
| act_sel | input | 1 | 0 linear, 1 clip to -512..511 |
| out_valid | output | 1 | Result column available |
| out_ready | input | 1 | Consumer takes the result column |
| out_res | output | 44 | 4 signed 11-bit results, result i in bits [11i+10:11i] |
| out_sot | output | 1 | Result column starts a tile |
| out_eot | output | 1 | Result column ends a tile |

## Verification
Several properties are checked on every cycle. The output must hold steady under backpressure. A column must arrive two cycles after acceptance when nothing stalls. Clipped outputs must stay within range, and the mode must not change while a column is in flight. The end marker must appear only with valid data. The numeric accuracy of the shift-and-add products and the exact floor-and-wrap behaviour can only be shown by the bench, which compares against a dot product computed independently over real image columns and extreme columns. The same holds for the marker positions across a full tile and for the rule that a mid-tile mode change is ignored.

// File: rtl/fixed_weight_encoder.sv
module fixed_weight_encoder #(
  parameter int N_IN      = 16,
  parameter int N_OUT     = 4,
  parameter int PIX_W     = 8,
  parameter int W_FRAC    = 12,
  parameter int OUT_W     = 11,
  parameter int TILE_COLS = 16,
  parameter int WT [N_OUT*N_IN] = '{
     2732,  1968,   559,  -437,  1870,  1524,   851,   487,
      530,   805,  1229,  1508,  -591,   263,  1585,  2484,
     1640,  1019,  -236, -1230,   -97,  -381,  -771,  -899,
    -2372, -2048, -1128,   553, -4096, -3338, -1378,   -81,
     4095,  4095,  2495,   867,  2800,  2768,  2392,  2182,
     -586,   527,  2414,  3450, -3475, -1222,  2411,  4095,
      101,   405,   801,  1073,     9,    43,   140,   224,
      -59,  -319,  -319,  -817,  -220,  -698, -1339, -1755}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N_IN*PIX_W-1:0]    in_pix,
  input  logic                     in_sot,
  input  logic                     act_sel,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [N_OUT*OUT_W-1:0]   out_res,
  output logic                     out_sot,
  output logic                     out_eot
);
  localparam int ACC_W  = PIX_W + W_FRAC + 2 + $clog2(N_IN);
  localparam int CNT_W  = (TILE_COLS > 1) ? $clog2(TILE_COLS) : 1;
  localparam int SAT_HI = 2**(OUT_W-2) - 1;
  localparam int SAT_LO = -(2**(OUT_W-2));

  logic signed [ACC_W-1:0] dot    [N_OUT];
  logic signed [ACC_W-1:0] s1_acc [N_OUT];
  logic                    s1_v, s1_sot, o_v, o_sot, act_q;
  logic [CNT_W-1:0]        col_cnt;
  logic                    adv, idle, last_col;

  // Canonical-signed-digit recoding of a constant weight: each nonzero
  // digit adds or subtracts one shifted copy of the pixel.
  function automatic logic signed [ACC_W-1:0] csd_scale(input logic [PIX_W-1:0] p, input int w);
    logic signed [ACC_W-1:0] acc, px;
    int x;
    acc = '0;
    px  = $signed({{(ACC_W-PIX_W){1'b0}}, p});
    x   = w;
    for (int b = 0; b <= W_FRAC + 1; b++) begin
      if (x[0]) begin
        if (x[1]) begin acc = acc - (px <<< b); x = x + 1; end
        else      begin acc = acc + (px <<< b); x = x - 1; end
      end
      x = x >>> 1;
    end
    return acc;
  endfunction

  function automatic logic [OUT_W-1:0] shape(input logic signed [ACC_W-1:0] a, input logic clip);
    logic signed [ACC_W-1:0] fl;
    fl = a >>> W_FRAC;
    if (clip && fl > $signed(ACC_W'(SAT_HI)))      fl = $signed(ACC_W'(SAT_HI));
    else if (clip && fl < $signed(ACC_W'(SAT_LO))) fl = $signed(ACC_W'(SAT_LO));
    return fl[OUT_W-1:0];
  endfunction

  always_comb begin
    for (int i = 0; i < N_OUT; i++) begin
      dot[i] = '0;
      for (int j = 0; j < N_IN; j++)
        dot[i] = dot[i] + csd_scale(in_pix[j*PIX_W +: PIX_W], WT[i*N_IN+j]);
    end
  end

  assign adv       = !(o_v && !out_ready);
  assign in_ready  = adv;
  assign idle      = !s1_v && !o_v && (col_cnt == '0);
  assign last_col  = (col_cnt == CNT_W'(TILE_COLS-1));
  assign out_valid = o_v;
  assign out_sot   = o_v && o_sot;
  assign out_eot   = o_v && last_col;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      o_v     <= 1'b0;
      o_sot   <= 1'b0;
      col_cnt <= '0;
      act_q   <= 1'b0;
    end else begin
      if (idle) act_q <= act_sel;
      if (adv) begin
        s1_v  <= in_valid;
        o_v   <= s1_v;
        o_sot <= s1_sot;
      end
      if (o_v && out_ready) col_cnt <= last_col ? '0 : col_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      s1_acc <= dot;
      s1_sot <= in_sot;
    end
    if (adv && s1_v)
      for (int i = 0; i < N_OUT; i++)
        out_res[i*OUT_W +: OUT_W] <= shape(s1_acc[i], act_q);
  end
endmodule

// File: rtl/fixed_weight_encoder_chk.sv
module fixed_weight_encoder_chk #(
  parameter int N_OUT = 4,
  parameter int OUT_W = 11
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [N_OUT*OUT_W-1:0] out_res,
  input logic                   out_sot,
  input logic                   out_eot,
  input logic                   act_q,
  input logic                   s1_v,
  input logic                   o_v
);
  function automatic logic all_in_range(input logic [N_OUT*OUT_W-1:0] r);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < N_OUT; i++)
      if ($signed(r[i*OUT_W +: OUT_W]) > 2**(OUT_W-2) - 1 ||
          $signed(r[i*OUT_W +: OUT_W]) < -(2**(OUT_W-2))) ok = 1'b0;
    return ok;
  endfunction

  assert_rst_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready && !out_eot));

  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) ##1 (out_ready || !out_valid) |=> out_valid);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_sot)));

  assert_clip_range_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && act_q) |-> all_in_range(out_res));

  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (s1_v || o_v) |=> $stable(act_q));

  assert_eot_valid_R8: assert property (@(posedge clk) disable iff (rst)
    out_eot |-> out_valid);
endmodule

bind fixed_weight_encoder fixed_weight_encoder_chk #(.N_OUT(N_OUT), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
  .out_sot(out_sot), .out_eot(out_eot), .act_q(act_q), .s1_v(s1_v), .o_v(o_v)
);

// File: tb/test_fixed_weight_encoder.sv
module test_fixed_weight_encoder;
  localparam int NI = 16, NO = 4, OW = 11;
  localparam int W [NO*NI] = '{
     2732,  1968,   559,  -437,  1870,  1524,   851,   487,
      530,   805,  1229,  1508,  -591,   263,  1585,  2484,
     1640,  1019,  -236, -1230,   -97,  -381,  -771,  -899,
    -2372, -2048, -1128,   553, -4096, -3338, -1378,   -81,
     4095,  4095,  2495,   867,  2800,  2768,  2392,  2182,
     -586,   527,  2414,  3450, -3475, -1222,  2411,  4095,
      101,   405,   801,  1073,     9,    43,   140,   224,
      -59,  -319,  -319,  -817,  -220,  -698, -1339, -1755};
  localparam int VEC [6][NI] = '{
    '{102, 90, 98,102,101,157,171,179,186,172,180,145,103,103,101,101},
    '{102,104,103,106,106,164,170,172,182,176,179,178,115,100, 96,104},
    '{105, 93, 96, 89,118,172,168,171,173,182,176,180,164,109,109,102},
    '{  0,  0,  0,  0,  0,  0,  0,  0,  0,  0,  0,  0,  0,  0,  0,  0},
    '{255,255,255,255,255,255,255,255,255,255,255,255,255,255,255,255},
    '{255,  0,255,  0,255,  0,255,  0,255,  0,255,  0,255,  0,255,  0}};

  logic clk = 0, rst = 1, in_valid = 0, in_sot = 0, act_sel = 0, out_ready = 1;
  logic [NI*8-1:0] in_pix = '0;
  logic in_ready, out_valid, out_sot, out_eot;
  logic [NO*OW-1:0] out_res;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  fixed_weight_encoder i_fixed_weight_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .in_sot(in_sot), .act_sel(act_sel), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_sot(out_sot), .out_eot(out_eot));

  function automatic logic [NI*8-1:0] col(input int k);
    logic [NI*8-1:0] p;
    for (int j = 0; j < NI; j++) p[j*8 +: 8] = 8'(VEC[k][j]);
    return p;
  endfunction

  function automatic logic [OW-1:0] model(input logic [NI*8-1:0] p, input int i, input logic clip);
    logic signed [31:0] s;
    s = 0;
    for (int j = 0; j < NI; j++) s = s + W[i*NI+j] * int'(p[j*8 +: 8]);
    s = s >>> 12;
    if (clip && s > 511) s = 511;
    if (clip && s < -512) s = -512;
    return s[OW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_res(input logic [NI*8-1:0] p, input logic clip, input string req);
    for (int i = 0; i < NO; i++)
      chk(out_res[i*OW +: OW] == model(p, i, clip), req,
          $signed(out_res[i*OW +: OW]), $signed(model(p, i, clip)));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic push(input logic [NI*8-1:0] p, input logic sot);
    @(negedge clk);
    in_pix = p; in_sot = sot; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_sot = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0 && out_eot == 0, "R1 after release", out_valid, 0);

    // R2/R3/R7 table walk in linear mode
    for (int k = 0; k < 6; k++) begin
      push(col(k), k == 0);
      chk(out_valid == 0, "R3 not early", out_valid, 0);
      @(negedge clk);
      chk(out_valid == 1, "R3 two cycles", out_valid, 1);
      chk(out_sot == (k == 0), "R7 sot", out_sot, k == 0);
      chk_res(col(k), 0, "R2 linear");
    end

    // R1/R8 full tile after reset, markers
    do_reset();
    for (int c = 0; c < 16; c++) begin
      push(col(c % 6), c == 0);
      @(negedge clk);
      chk(out_eot == (c == 15), "R8 eot", out_eot, c == 15);
      chk(out_sot == (c == 0), "R7 sot tile", out_sot, c == 0);
    end

    // R5 clipping, R6 mid-tile mode change ignored
    do_reset();
    act_sel = 1;
    push(col(0), 1);
    @(negedge clk);
    chk_res(col(0), 1, "R5 clip");
    act_sel = 0;
    push(col(4), 0);
    @(negedge clk);
    chk_res(col(4), 1, "R6 mode held");
    push(col(0), 0);
    @(negedge clk);
    chk_res(col(0), 1, "R6 mode held 2");

    // R4 backpressure
    do_reset();
    out_ready = 0;
    push(col(1), 1);
    @(negedge clk);
    chk(out_valid == 1, "R4 first out", out_valid, 1);
    in_pix = col(2); in_valid = 1;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      chk(in_ready == 0, "R4 in_ready low", in_ready, 0);
      chk(out_valid == 1 && out_sot == 1, "R4 valid held", out_valid, 1);
      chk_res(col(1), 0, "R4 data held");
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 0, "R4 drained", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1 && out_sot == 0, "R4 next column", out_valid, 1);
    chk_res(col(2), 0, "R4 next data");

    finish_run();
  end
endmodule